// File: doc/BRIEF.md
# Banked Internal Data Operand Resolver

This block gives an 8-bit controller's data path a single port for reading and writing byte operands held in on-chip storage. It owns three storage spaces: a 128-byte lower data RAM, a 128-byte upper data RAM and a file of 24 special-function registers (SFRs). The caller supplies an addressing mode, an 8-bit address or a 3-bit register number, the processor status word and a read or write request. The block works out which space and which location the operand lives in. It returns the read data in the same cycle and raises one write strobe per space.

The register bank is picked on every access from two status-word bits. The 0x80–0xFF half of the byte address space leads to different storage depending on how it is reached. Direct addressing lands in the SFR file. An operand reached through a pointer register lands in upper RAM, and so does an operand reached through the stack pointer. The stack pointer is the SFR at 0x81, so software can move it with an ordinary direct write.

There is no state machine. The block is a combinational router in front of three register-based stores. Its only clocked state is the stored bytes themselves.

Top module: `opres_top`

## Requirements
- R1: In mode 2'b00 (register), the operand is lower-RAM location 8*{psw[4],psw[3]} + reg_sel. This gives banks at 0, 8, 16 and 24. All other psw bits have no effect.
- R2: In mode 2'b01 (direct), an address below 0x80 selects lower-RAM location addr[6:0].
- R3: In direct mode, an address of 0x80 or above selects the SFR file. The implemented addresses are 0x81–0x83, 0x87–0x8D, 0x90, 0x98, 0x99, 0xA8, 0xB0, 0xB8, 0xC8, 0xCA–0xCD, 0xD0, 0xE0 and 0xF0. A value written to one of them reads back unchanged, and writing one never alters another.
- R4: A direct access at or above 0x80 to any other address raises bad_sfr in the same cycle. Such a write changes no storage and raises no strobe, and such a read returns 0x00.
- R5: In mode 2'b10 (indirect), the pointer is R0 of the current bank when reg_sel[0] is 0 and R1 when it is 1. A pointer with bit 7 set addresses upper RAM and one with bit 7 clear addresses lower RAM, in both cases at pointer[6:0].
- R6: In mode 2'b11 (stack), the address is the stack-pointer SFR (0x81), and the same bit-7 rule as R5 picks the RAM. The addr and reg_sel inputs are ignored.
- R7: After reset, the stack pointer reads 0x07. Every other SFR and every RAM byte reads 0x00.
- R8: A write takes effect at the next rising clock edge, and a read of the same location in the following cycle returns the new value. rd_data is 0x00 whenever rd_en is low.
- R9: During a write, exactly one of wr_lo, wr_hi and wr_sfr is high, and it names the space being written. No strobe is high without wr_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Addressing mode: 00 register, 01 direct, 10 indirect, 11 stack |
| addr | input | 8 | Byte address for direct mode |
| reg_sel | input | 3 | Register number (bit 0 alone picks R0/R1 in indirect mode) |
| psw | input | 8 | Processor status word; bits 4:3 choose the bank |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Operand value, combinational |
| wr_lo | output | 1 | Write strobe for lower RAM |
| wr_hi | output | 1 | Write strobe for upper RAM |
| wr_sfr | output | 1 | Write strobe for the SFR file |
| bad_sfr | output | 1 | Direct access to an unimplemented SFR address |

## Verification
The bench writes the same register number in all four banks and then reads each copy back by direct address. A design that ignores or swaps the bank bits returns the wrong byte. It sets a pointer and the stack pointer to 0x90 and 0x85, then reads 0x90 and 0x05 directly. A design that sends indirect or stack traffic to the SFR file, or drops bit 7, corrupts port 0x90 or leaves a stray byte in lower RAM. It writes to the unimplemented address 0x80 and then checks the error flag, the absence of strobes and a zero read. It also checks the stack pointer's reset value of 0x07 before and after a reset in mid-run, which catches an SFR file that clears every slot alike.

// File: rtl/opres_pkg.sv
package opres_pkg;

    typedef enum logic [1:0] {
        AM_REG = 2'd0,
        AM_DIR = 2'd1,
        AM_IND = 2'd2,
        AM_STK = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        SPC_NONE = 2'd0,
        SPC_LO   = 2'd1,
        SPC_HI   = 2'd2,
        SPC_SFR  = 2'd3
    } space_e;

    localparam int SFR_SLOTS = 24;
    localparam int SLOT_W    = $clog2(SFR_SLOTS);
    localparam int SLOT_SP   = 0;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
    } sfr_hit_t;

    // Maps an SFR byte address onto a dense storage slot.
    function automatic sfr_hit_t sfr_lookup(input logic [7:0] a);
        sfr_hit_t r;
        r.hit  = 1'b1;
        r.slot = '0;
        unique case (a)
            8'h81: r.slot = SLOT_W'(0);
            8'h82: r.slot = SLOT_W'(1);
            8'h83: r.slot = SLOT_W'(2);
            8'h87: r.slot = SLOT_W'(3);
            8'h88: r.slot = SLOT_W'(4);
            8'h89: r.slot = SLOT_W'(5);
            8'h8A: r.slot = SLOT_W'(6);
            8'h8B: r.slot = SLOT_W'(7);
            8'h8C: r.slot = SLOT_W'(8);
            8'h8D: r.slot = SLOT_W'(9);
            8'h90: r.slot = SLOT_W'(10);
            8'h98: r.slot = SLOT_W'(11);
            8'h99: r.slot = SLOT_W'(12);
            8'hA8: r.slot = SLOT_W'(13);
            8'hB0: r.slot = SLOT_W'(14);
            8'hB8: r.slot = SLOT_W'(15);
            8'hC8: r.slot = SLOT_W'(16);
            8'hCA: r.slot = SLOT_W'(17);
            8'hCB: r.slot = SLOT_W'(18);
            8'hCC: r.slot = SLOT_W'(19);
            8'hCD: r.slot = SLOT_W'(20);
            8'hD0: r.slot = SLOT_W'(21);
            8'hE0: r.slot = SLOT_W'(22);
            8'hF0: r.slot = SLOT_W'(23);
            default: r.hit = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/opres_ram.sv
module opres_ram #(
    parameter int DW = 8,
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx_a,
    output logic [DW-1:0] rdata_a,
    input  logic [IW-1:0] ridx_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << IW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata_a = mem[ridx_a];
    assign rdata_b = mem[ridx_b];

    // R8
    ram_write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(widx)] == $past(wdata));

endmodule

// File: rtl/opres_sfr.sv
module opres_sfr
    import opres_pkg::*;
#(
    parameter int          DW     = 8,
    parameter logic [DW-1:0] SP_RST = DW'(7)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] wslot,
    input  logic [DW-1:0]     wdata,
    input  logic [SLOT_W-1:0] rslot,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     sp
);
    logic [DW-1:0] regs [SFR_SLOTS];

    for (genvar g = 0; g < SFR_SLOTS; g++) begin : g_slot
        localparam logic [DW-1:0] RST = (g == SLOT_SP) ? SP_RST : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           regs[g] <= RST;
            else if (we && wslot == SLOT_W'(g))   regs[g] <= wdata;
        end
    end

    assign rdata = (int'(rslot) < SFR_SLOTS) ? regs[rslot] : '0;
    assign sp    = regs[SLOT_SP];

    // R7
    // sp_reset_value_chk
    sp_reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sp == SP_RST);

endmodule

// File: rtl/opres_route.sv
module opres_route
    import opres_pkg::*;
#(
    parameter int DW = 8,
    parameter int IW = 7
) (
    input  amode_e            mode,
    input  logic [DW-1:0]     addr,
    input  logic [2:0]        reg_sel,
    input  logic [1:0]        bank,
    input  logic [DW-1:0]     ptr,
    input  logic [DW-1:0]     sp,
    output logic [IW-1:0]     ptr_idx,
    output space_e            space,
    output logic [IW-1:0]     idx,
    output logic [SLOT_W-1:0] slot,
    output logic              bad
);
    localparam int PAD = IW - 5;

    sfr_hit_t hit;
    logic [DW-1:0] via;

    assign hit     = sfr_lookup(addr[7:0]);
    assign ptr_idx = {{PAD{1'b0}}, bank, 2'b00, reg_sel[0]};
    assign via     = (mode == AM_STK) ? sp : ptr;

    always_comb begin
        space = SPC_NONE;
        idx   = '0;
        slot  = '0;
        bad   = 1'b0;
        unique case (mode)
            AM_REG: begin
                space = SPC_LO;
                idx   = {{PAD{1'b0}}, bank, reg_sel};
            end
            AM_DIR: begin
                if (!addr[DW-1]) begin
                    space = SPC_LO;
                    idx   = addr[IW-1:0];
                end else if (hit.hit) begin
                    space = SPC_SFR;
                    slot  = hit.slot;
                end else begin
                    bad = 1'b1;
                end
            end
            AM_IND, AM_STK: begin
                space = via[DW-1] ? SPC_HI : SPC_LO;
                idx   = via[IW-1:0];
            end
            default: space = SPC_NONE;
        endcase
    end

endmodule

// File: rtl/opres_top.sv
module opres_top
    import opres_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic [DW-1:0] addr,
    input  logic [2:0]    reg_sel,
    input  logic [7:0]    psw,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          wr_lo,
    output logic          wr_hi,
    output logic          wr_sfr,
    output logic          bad_sfr
);
    localparam int IW = DW - 1;

    amode_e            am;
    space_e            space;
    logic [IW-1:0]     idx, ptr_idx;
    logic [SLOT_W-1:0] slot;
    logic              bad;
    logic [DW-1:0]     lo_rd, ptr_val, hi_rd, hi_unused_b, sfr_rd, sp;
    logic              unused_psw;

    assign am         = amode_e'(mode);
    assign unused_psw = ^{psw[7:5], psw[2:0], hi_unused_b};

    opres_route #(.DW(DW), .IW(IW)) u_route (
        .mode(am), .addr(addr), .reg_sel(reg_sel), .bank(psw[4:3]),
        .ptr(ptr_val), .sp(sp), .ptr_idx(ptr_idx), .space(space),
        .idx(idx), .slot(slot), .bad(bad)
    );

    opres_ram #(.DW(DW), .IW(IW)) u_lo (
        .clk(clk), .rst_n(rst_n), .we(wr_lo), .widx(idx), .wdata(wr_data),
        .ridx_a(idx), .rdata_a(lo_rd), .ridx_b(ptr_idx), .rdata_b(ptr_val)
    );

    opres_ram #(.DW(DW), .IW(IW)) u_hi (
        .clk(clk), .rst_n(rst_n), .we(wr_hi), .widx(idx), .wdata(wr_data),
        .ridx_a(idx), .rdata_a(hi_rd), .ridx_b('0), .rdata_b(hi_unused_b)
    );

    opres_sfr #(.DW(DW)) u_sfr (
        .clk(clk), .rst_n(rst_n), .we(wr_sfr), .wslot(slot), .wdata(wr_data),
        .rslot(slot), .rdata(sfr_rd), .sp(sp)
    );

    assign wr_lo   = wr_en && space == SPC_LO;
    assign wr_hi   = wr_en && space == SPC_HI;
    assign wr_sfr  = wr_en && space == SPC_SFR;
    assign bad_sfr = (rd_en || wr_en) && bad;

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (space)
                SPC_LO:  rd_data = lo_rd;
                SPC_HI:  rd_data = hi_rd;
                SPC_SFR: rd_data = sfr_rd;
                default: rd_data = '0;
            endcase
        end
    end

    // R9
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_lo, wr_hi, wr_sfr}) && (wr_en || !(wr_lo || wr_hi || wr_sfr)));

    // R4
    bad_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_sfr |-> !wr_lo && !wr_hi && !wr_sfr);

    // R4
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_sfr && rd_en) |-> rd_data == '0);

    // R6
    stack_to_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == 2'b11) |-> (wr_lo || wr_hi) && wr_hi == sp[DW-1]);

    // R5
    sp_stable_on_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |=> $stable(sp));

endmodule

// File: tb/opres_top_bench.sv
module opres_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = '0;
    logic [7:0] addr = '0;
    logic [2:0] reg_sel = '0;
    logic [7:0] psw = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       wr_lo, wr_hi, wr_sfr, bad_sfr;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    opres_top u_opres_top (
        .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .reg_sel(reg_sel),
        .psw(psw), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_sfr(wr_sfr),
        .bad_sfr(bad_sfr)
    );

    // {req4, mode2, addr8, rsel3, bank2, wr1, data8, exp8, strobes{lo,hi,sfr}3, bad1}
    localparam int NV = 32;
    localparam logic [39:0] VEC [NV] = '{
        {4'd1, 2'd0, 8'h00, 3'd3, 2'd0, 1'b1, 8'h11, 8'h00, 3'b100, 1'b0}, // R1 bank0
        {4'd1, 2'd0, 8'h00, 3'd3, 2'd1, 1'b1, 8'h22, 8'h00, 3'b100, 1'b0}, // R1 bank1
        {4'd1, 2'd0, 8'h00, 3'd3, 2'd2, 1'b1, 8'h33, 8'h00, 3'b100, 1'b0}, // R1 bank2
        {4'd1, 2'd0, 8'h00, 3'd3, 2'd3, 1'b1, 8'h44, 8'h00, 3'b100, 1'b0}, // R1 bank3
        {4'd2, 2'd1, 8'h03, 3'd0, 2'd0, 1'b0, 8'h00, 8'h11, 3'b000, 1'b0}, // R2
        {4'd2, 2'd1, 8'h0B, 3'd0, 2'd0, 1'b0, 8'h00, 8'h22, 3'b000, 1'b0}, // R2
        {4'd2, 2'd1, 8'h13, 3'd0, 2'd0, 1'b0, 8'h00, 8'h33, 3'b000, 1'b0}, // R2
        {4'd2, 2'd1, 8'h1B, 3'd0, 2'd0, 1'b0, 8'h00, 8'h44, 3'b000, 1'b0}, // R2
        {4'd3, 2'd1, 8'h90, 3'd0, 2'd0, 1'b1, 8'h5A, 8'h00, 3'b001, 1'b0}, // R3
        {4'd1, 2'd0, 8'h00, 3'd0, 2'd2, 1'b1, 8'h90, 8'h00, 3'b100, 1'b0}, // R1 ptr=0x90
        {4'd5, 2'd2, 8'h00, 3'd0, 2'd2, 1'b1, 8'hA5, 8'h00, 3'b010, 1'b0}, // R5 to upper
        {4'd5, 2'd2, 8'h00, 3'd0, 2'd2, 1'b0, 8'h00, 8'hA5, 3'b000, 1'b0}, // R5
        {4'd3, 2'd1, 8'h90, 3'd0, 2'd0, 1'b0, 8'h00, 8'h5A, 3'b000, 1'b0}, // R3 untouched
        {4'd1, 2'd0, 8'h00, 3'd1, 2'd3, 1'b1, 8'h40, 8'h00, 3'b100, 1'b0}, // R1 ptr=0x40
        {4'd5, 2'd2, 8'h00, 3'd7, 2'd3, 1'b1, 8'h77, 8'h00, 3'b100, 1'b0}, // R5 R1 lower
        {4'd2, 2'd1, 8'h40, 3'd0, 2'd0, 1'b0, 8'h00, 8'h77, 3'b000, 1'b0}, // R2
        {4'd6, 2'd3, 8'hFF, 3'd5, 2'd1, 1'b0, 8'h00, 8'h00, 3'b000, 1'b0}, // R6 sp=7
        {4'd6, 2'd3, 8'hFF, 3'd5, 2'd1, 1'b1, 8'h66, 8'h00, 3'b100, 1'b0}, // R6
        {4'd1, 2'd0, 8'h00, 3'd7, 2'd0, 1'b0, 8'h00, 8'h66, 3'b000, 1'b0}, // R1
        {4'd3, 2'd1, 8'h81, 3'd0, 2'd0, 1'b1, 8'h85, 8'h00, 3'b001, 1'b0}, // R3 sp
        {4'd6, 2'd3, 8'h00, 3'd0, 2'd0, 1'b1, 8'h99, 8'h00, 3'b010, 1'b0}, // R6 upper
        {4'd3, 2'd1, 8'h81, 3'd0, 2'd0, 1'b0, 8'h00, 8'h85, 3'b000, 1'b0}, // R3
        {4'd6, 2'd3, 8'h05, 3'd0, 2'd0, 1'b0, 8'h00, 8'h99, 3'b000, 1'b0}, // R6
        {4'd6, 2'd1, 8'h05, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 3'b000, 1'b0}, // R6 lower clean
        {4'd4, 2'd1, 8'h80, 3'd0, 2'd0, 1'b1, 8'h12, 8'h00, 3'b000, 1'b1}, // R4
        {4'd4, 2'd1, 8'h80, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 3'b000, 1'b1}, // R4
        {4'd4, 2'd1, 8'hC9, 3'd0, 2'd0, 1'b1, 8'hEE, 8'h00, 3'b000, 1'b1}, // R4
        {4'd7, 2'd1, 8'hF0, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 3'b000, 1'b0}, // R7
        {4'd8, 2'd1, 8'hF0, 3'd0, 2'd0, 1'b1, 8'hC3, 8'h00, 3'b001, 1'b0}, // R8
        {4'd8, 2'd1, 8'hF0, 3'd0, 2'd0, 1'b0, 8'h00, 8'hC3, 3'b000, 1'b0}, // R8
        {4'd3, 2'd1, 8'hCD, 3'd0, 2'd0, 1'b1, 8'h3C, 8'h00, 3'b001, 1'b0}, // R3
        {4'd3, 2'd1, 8'hCC, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 3'b000, 1'b0}  // R3 neighbour
    };

    task automatic check(input bit ok, input int req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic op(input logic [1:0] m, input logic [7:0] a, input logic [2:0] rs,
                      input logic [1:0] bk, input bit wr, input logic [7:0] d,
                      input logic [7:0] exp, input logic [2:0] strb, input bit bad,
                      input int req);
        @(negedge clk);
        mode = m; addr = a; reg_sel = rs;
        psw = {3'b101, bk, 3'b011};
        wr_en = wr; rd_en = !wr; wr_data = d;
        #1;
        check(rd_data == exp && {wr_lo, wr_hi, wr_sfr} == strb && bad_sfr == bad, req,
              $sformatf("mode %0d addr %02h strobes %03b bad %0b", m, a,
                        {wr_lo, wr_hi, wr_sfr}, bad_sfr), rd_data, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R7 reset values
        op(2'd1, 8'h81, 3'd0, 2'd0, 1'b0, 8'h00, 8'h07, 3'b000, 1'b0, 7);
        op(2'd1, 8'h90, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 3'b000, 1'b0, 7);
        op(2'd1, 8'h7F, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 3'b000, 1'b0, 7);
        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            v = VEC[i];
            op(v[35:34], v[33:26], v[25:23], v[22:21], v[20], v[19:12],
               v[11:4], v[3:1], v[0], int'(v[39:36]));
        end
        // R4 ignored write leaves low RAM index 0 and 0x49 (0xC9 & 0x7F) untouched
        op(2'd1, 8'h00, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 3'b000, 1'b0, 4);
        op(2'd1, 8'h49, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 3'b000, 1'b0, 4);
        // R8 idle read returns zero
        @(negedge clk);
        mode = 2'd1; addr = 8'h81; rd_en = 1'b0; wr_en = 1'b0;
        #1;
        check(rd_data == 8'h00, 8, "idle rd_data", rd_data, 8'h00);
        // R7 reset mid-run
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        op(2'd1, 8'h81, 3'd0, 2'd0, 1'b0, 8'h00, 8'h07, 3'b000, 1'b0, 7);
        op(2'd1, 8'h40, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 3'b000, 1'b0, 7);
        op(2'd1, 8'hF0, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 3'b000, 1'b0, 7);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule